// File: doc/BRIEF.md
# Tune Command Decoder

This block turns a ten-byte tuning request into the set of configuration values a satellite demodulator expects. The request arrives one byte per valid cycle, with a last marker on the final byte. From it the block takes a 32-bit symbol rate, a 32-bit intermediate frequency, a modulation index and an FEC index. When the request is accepted, it produces both 32-bit values in the demodulator's byte order, plus a code-rate byte, a modulation-type byte, a demodulator-mode byte and a turbo flag.

Code-rate bytes, and the Digicipher II modulation-type bytes, are read from five small tables. The tables are loaded through a write-only register port, one table per modulation family. A request is rejected in three cases: the modulation index is out of range, the FEC index is beyond the family's limit, or the frame does not hold exactly ten bytes. A rejected request raises one error pulse and leaves every configuration output as it was.

A result strobe reports each accepted request. The surrounding logic uses it to start programming the demodulator.

Top module: `tune_decoder`

## Requirements
- R1: After reset, all configuration outputs are zero and cfgValid, errMod, errFec and errLen are low.
- R2: Payload bytes 0..3 carry the symbol rate and bytes 4..7 carry the frequency, least significant byte first. In the output bus, byte lane k (bits 8k+7:8k) is the k-th byte sent to the demodulator, and lane 0 is the most significant byte. So freqCfg[7:0] = byte 7 and freqCfg[31:24] = byte 4; symRateCfg[7:0] = byte 3 and symRateCfg[31:24] = byte 0.
- R3: Modulation 0 (DVB-S QPSK) yields codeRate = table 0 [FEC], modType 0x09, demodMode 0x10 and turboFlag 0x00.
- R4: Modulations 1, 2 and 3 (turbo QPSK, 8PSK, 16QAM) yield codeRate = table 1, 2 or 3 [FEC] respectively, modType 0x09, demodMode 0x10 and turboFlag 0x01.
- R5: Modulations 4 to 7 (Digicipher II) yield the following:
  - codeRate is fixed at 0xFC.
  - modType = table 4 [FEC].
  - turboFlag is 0x00.
  - demodMode is 0x10 for 4, 0x12 for 5, 0x16 for 6 and 0x11 for 7.
- R6: Modulations 8 (DSS) and 9 (BPSK) yield codeRate = table 0 [FEC] OR 0x80, modType 0x09, demodMode 0x10 and turboFlag 0x00.
- R7: The largest legal FEC index is:
  - 7 for modulations 0, 8 and 9;
  - 5 for modulations 1 and 2;
  - 1 for modulation 3;
  - 9 for modulations 4 to 7.

  A larger index gives a one-cycle errFec pulse, no cfgValid, and unchanged outputs.
- R8: A modulation index of 10 or more gives a one-cycle errMod pulse, no cfgValid, no errFec, and unchanged outputs.
- R9: A frame whose last byte is not its tenth valid byte gives a one-cycle errLen pulse. It gives no cfgValid, no errMod and no errFec, and the outputs stay unchanged.
- R10: timing and strobe behaviour.
  - errLen is high in the cycle after the clock edge that takes the last byte.
  - For a ten-byte frame, the outputs and exactly one of cfgValid, errMod and errFec change one cycle after that.
  - cfgValid lasts one cycle.
- R11: Table write: when tblWrEn is high, tblData is stored into table tblFamily (0 to 4) at entry tblAddr (the FEC index). Table sizes are 8, 6, 6, 2 and 10 entries. The new value is used by the next accepted request.
- R12: Cycles with inValid low between bytes of a frame have no effect on parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | inData holds a payload byte |
| inData | input | 8 | Payload byte |
| inLast | input | 1 | This byte ends the frame |
| tblWrEn | input | 1 | Table write enable |
| tblFamily | input | 3 | Table select, 0 to 4 |
| tblAddr | input | 4 | Table entry (FEC index) |
| tblData | input | 8 | Table write data |
| symRateCfg | output | 32 | Symbol rate in demodulator byte order |
| freqCfg | output | 32 | Frequency in demodulator byte order |
| codeRate | output | 8 | FEC code-rate byte |
| modType | output | 8 | Modulation type byte |
| demodMode | output | 8 | Demodulator mode byte |
| turboFlag | output | 8 | 0x01 for turbo modulations, else 0x00 |
| cfgValid | output | 1 | One-cycle strobe: new configuration accepted |
| errMod | output | 1 | One-cycle strobe: modulation index rejected |
| errFec | output | 1 | One-cycle strobe: FEC index rejected |
| errLen | output | 1 | One-cycle strobe: frame length rejected |

## Verification
The byte counter is the one piece of control state that can go wrong. If it drifts, the very next frame ends with errLen instead of cfgValid, or the bytes land one lane off in freqCfg and symRateCfg. Either fault shows up within two cycles of that frame's last byte.

A stale or mis-addressed table entry appears as a wrong codeRate or modType on the first accepted request that uses that entry. A rejected request that still changed state would show as a changed output while an error strobe is high. So each rejection is followed by a comparison against the values held from the last accepted request.

// File: rtl/tune_pkg.sv
package tune_pkg;
  localparam int BYTE_W      = 8;
  localparam int PAY_LEN     = 10;
  localparam int MOD_COUNT   = 10;
  localparam int FAM_COUNT   = 5;
  localparam int MAX_DEPTH   = 10;
  localparam int IDX_W       = $clog2(PAY_LEN + 1);
  localparam int FAM_W       = $clog2(FAM_COUNT);
  localparam int TBL_ADDR_W  = $clog2(MAX_DEPTH);

  localparam logic [BYTE_W-1:0] MODTYPE_STD = 8'h09;
  localparam logic [BYTE_W-1:0] MODE_STD    = 8'h10;
  localparam logic [BYTE_W-1:0] MODE_OQPSK  = 8'h11;
  localparam logic [BYTE_W-1:0] MODE_ISTRM  = 8'h12;
  localparam logic [BYTE_W-1:0] MODE_QSTRM  = 8'h16;
  localparam logic [BYTE_W-1:0] DCII_RATE   = 8'hFC;
  localparam logic [BYTE_W-1:0] HIGH_BIT    = 8'h80;

  // control -> datapath strobes
  typedef struct packed {
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
    logic             check;
  } tuneCmd_t;

  // entries per family table = largest legal FEC index + 1
  function automatic int famDepth(input int fam);
    case (fam)
      0:       return 8;
      1:       return 6;
      2:       return 6;
      3:       return 2;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tune_ctrl.sv
module tune_ctrl
  import tune_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inLast,
  output tuneCmd_t cmd,
  output logic     errLen
);
  logic [IDX_W-1:0] byteCnt;
  logic             checkQ;

  always_comb begin
    cmd.capEn  = inValid && (byteCnt < IDX_W'(PAY_LEN));
    cmd.capIdx = byteCnt;
    cmd.check  = checkQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      checkQ  <= 1'b0;
      errLen  <= 1'b0;
    end else begin
      checkQ <= 1'b0;
      errLen <= 1'b0;
      if (inValid) begin
        if (inLast) begin
          byteCnt <= '0;
          if (byteCnt == IDX_W'(PAY_LEN - 1)) checkQ <= 1'b1;
          else                                errLen <= 1'b1;
        end else if (byteCnt != IDX_W'(PAY_LEN)) begin
          byteCnt <= byteCnt + 1'b1;
        end
      end
    end
  end

  AST_CHECK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    checkQ |-> $past(inValid && inLast)); // R10
  AST_LEN_ERR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    errLen |-> $past(inValid && inLast)); // R9
  AST_LEN_ERR_NOT_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    !(errLen && checkQ)); // R9
endmodule

// File: rtl/tune_data.sv
module tune_data
  import tune_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  tuneCmd_t              cmd,
  input  logic [BYTE_W-1:0]     inData,
  input  logic                  tblWrEn,
  input  logic [FAM_W-1:0]      tblFamily,
  input  logic [TBL_ADDR_W-1:0] tblAddr,
  input  logic [BYTE_W-1:0]     tblData,
  output logic [4*BYTE_W-1:0]   symRateCfg,
  output logic [4*BYTE_W-1:0]   freqCfg,
  output logic [BYTE_W-1:0]     codeRate,
  output logic [BYTE_W-1:0]     modType,
  output logic [BYTE_W-1:0]     demodMode,
  output logic [BYTE_W-1:0]     turboFlag,
  output logic                  cfgValid,
  output logic                  errMod,
  output logic                  errFec
);
  logic [BYTE_W-1:0] payQ [PAY_LEN];
  logic [BYTE_W-1:0] tblRd [FAM_COUNT];
  logic [BYTE_W-1:0] modIdx, fecIdx;
  logic [FAM_W-1:0]  fam;
  logic              modBad, fecBad;
  logic [BYTE_W-1:0] nxtRate, nxtType, nxtMode, nxtTurbo;

  assign modIdx = payQ[PAY_LEN-2];
  assign fecIdx = payQ[PAY_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAY_LEN; i++) payQ[i] <= '0;
    end else if (cmd.capEn) begin
      payQ[cmd.capIdx] <= inData;
    end
  end

  // one code table per modulation family
  for (genvar g = 0; g < FAM_COUNT; g++) begin : g_tbl
    localparam int DEPTH = famDepth(g);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (tblWrEn && tblFamily == FAM_W'(g) &&
                   tblAddr < TBL_ADDR_W'(DEPTH)) begin
        mem[tblAddr[AW-1:0]] <= tblData;
      end
    end

    assign tblRd[g] = (fecIdx < BYTE_W'(DEPTH)) ? mem[fecIdx[AW-1:0]] : '0;
  end

  always_comb begin
    modBad   = modIdx >= BYTE_W'(MOD_COUNT);
    nxtRate  = tblRd[0];
    nxtType  = MODTYPE_STD;
    nxtMode  = MODE_STD;
    nxtTurbo = '0;
    unique case (modIdx)
      8'd0:             fam = FAM_W'(0);
      8'd1, 8'd2, 8'd3: fam = modIdx[FAM_W-1:0];
      8'd8, 8'd9:       fam = FAM_W'(0);
      default:          fam = FAM_W'(4);
    endcase
    fecBad = fecIdx >= BYTE_W'(famDepth(int'(fam)));
    case (modIdx)
      8'd1, 8'd2, 8'd3: begin
        nxtRate  = tblRd[fam];
        nxtTurbo = 8'h01;
      end
      8'd4, 8'd5, 8'd6, 8'd7: begin
        nxtRate = DCII_RATE;
        nxtType = tblRd[4];
        if (modIdx == 8'd5)      nxtMode = MODE_ISTRM;
        else if (modIdx == 8'd6) nxtMode = MODE_QSTRM;
        else if (modIdx == 8'd7) nxtMode = MODE_OQPSK;
      end
      8'd8, 8'd9: nxtRate = tblRd[0] | HIGH_BIT;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symRateCfg <= '0;
      freqCfg    <= '0;
      codeRate   <= '0;
      modType    <= '0;
      demodMode  <= '0;
      turboFlag  <= '0;
      cfgValid   <= 1'b0;
      errMod     <= 1'b0;
      errFec     <= 1'b0;
    end else begin
      cfgValid <= 1'b0;
      errMod   <= 1'b0;
      errFec   <= 1'b0;
      if (cmd.check) begin
        if (modBad) begin
          errMod <= 1'b1;
        end else if (fecBad) begin
          errFec <= 1'b1;
        end else begin
          symRateCfg <= {payQ[0], payQ[1], payQ[2], payQ[3]};
          freqCfg    <= {payQ[4], payQ[5], payQ[6], payQ[7]};
          codeRate   <= nxtRate;
          modType    <= nxtType;
          demodMode  <= nxtMode;
          turboFlag  <= nxtTurbo;
          cfgValid   <= 1'b1;
        end
      end
    end
  end

  AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cfgValid, errMod, errFec})); // R10
  AST_RESULT_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid || errMod || errFec) |-> $past(cmd.check)); // R10
  AST_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (errMod || errFec) |-> ($stable(codeRate) && $stable(modType) &&
     $stable(demodMode) && $stable(turboFlag) && $stable(freqCfg) &&
     $stable(symRateCfg))); // R7
  AST_DCII_FIXED_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && demodMode != MODE_STD) |-> codeRate == DCII_RATE); // R5
  AST_TURBO_STD_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && turboFlag != 8'h00) |->
      (modType == MODTYPE_STD && demodMode == MODE_STD)); // R4
endmodule

// File: rtl/tune_decoder.sv
module tune_decoder
  import tune_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [BYTE_W-1:0]     inData,
  input  logic                  inLast,
  input  logic                  tblWrEn,
  input  logic [FAM_W-1:0]      tblFamily,
  input  logic [TBL_ADDR_W-1:0] tblAddr,
  input  logic [BYTE_W-1:0]     tblData,
  output logic [4*BYTE_W-1:0]   symRateCfg,
  output logic [4*BYTE_W-1:0]   freqCfg,
  output logic [BYTE_W-1:0]     codeRate,
  output logic [BYTE_W-1:0]     modType,
  output logic [BYTE_W-1:0]     demodMode,
  output logic [BYTE_W-1:0]     turboFlag,
  output logic                  cfgValid,
  output logic                  errMod,
  output logic                  errFec,
  output logic                  errLen
);
  tuneCmd_t cmd;

  tune_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .cmd     (cmd),
    .errLen  (errLen)
  );

  tune_data i_data (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .inData     (inData),
    .tblWrEn    (tblWrEn),
    .tblFamily  (tblFamily),
    .tblAddr    (tblAddr),
    .tblData    (tblData),
    .symRateCfg (symRateCfg),
    .freqCfg    (freqCfg),
    .codeRate   (codeRate),
    .modType    (modType),
    .demodMode  (demodMode),
    .turboFlag  (turboFlag),
    .cfgValid   (cfgValid),
    .errMod     (errMod),
    .errFec     (errFec)
  );
endmodule

// File: tb/test_tune_decoder.sv
module test_tune_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inLast = 1'b0, tblWrEn = 1'b0;
  logic [7:0]  inData = '0, tblData = '0;
  logic [2:0]  tblFamily = '0;
  logic [3:0]  tblAddr = '0;
  logic [31:0] symRateCfg, freqCfg;
  logic [7:0]  codeRate, modType, demodMode, turboFlag;
  logic        cfgValid, errMod, errFec, errLen;

  int nRun = 0, nFail = 0;
  logic        done = 1'b0;
  logic [7:0]  pay [12];
  logic [7:0]  tv [5][10];
  logic [31:0] expSym = '0, expFreq = '0;
  logic [7:0]  expRate = '0, expType = '0, expMode = '0, expTurbo = '0;

  always #5 clk = ~clk;

  tune_decoder i_tune_decoder (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeTbl(input int f, input int a, input logic [7:0] d);
    @(negedge clk);
    tblWrEn = 1'b1; tblFamily = 3'(f); tblAddr = 4'(a); tblData = d;
    @(negedge clk);
    tblWrEn = 1'b0;
    tv[f][a] = d;
  endtask

  // kind: 0 accept, 1 modulation error, 2 FEC error, 3 length error
  task automatic runTune(input string tag, input int m, input int f,
                         input logic [31:0] sym, input logic [31:0] freq,
                         input int len, input bit gap, input int kind);
    for (int i = 0; i < 4; i++) begin
      pay[i]   = sym[8*i +: 8];
      pay[4+i] = freq[8*i +: 8];
    end
    pay[8] = 8'(m); pay[9] = 8'(f); pay[10] = 8'hA5; pay[11] = 8'h5A;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = pay[i]; inLast = (i == len - 1);
      if (gap && i != len - 1) begin
        @(negedge clk);
        inValid = 1'b0; inData = 8'hEE; inLast = 1'b1;
      end
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    chk({tag, " errLen"}, 32'(errLen), 32'(kind == 3));
    @(negedge clk);
    chk({tag, " cfgValid"}, 32'(cfgValid), 32'(kind == 0));
    chk({tag, " errMod"}, 32'(errMod), 32'(kind == 1));
    chk({tag, " errFec"}, 32'(errFec), 32'(kind == 2));
    if (kind == 0) begin
      expSym   = {sym[7:0], sym[15:8], sym[23:16], sym[31:24]};
      expFreq  = {freq[7:0], freq[15:8], freq[23:16], freq[31:24]};
      expType  = 8'h09; expMode = 8'h10; expTurbo = 8'h00;
      if (m == 0)                 expRate = tv[0][f];
      else if (m >= 1 && m <= 3) begin expRate = tv[m][f]; expTurbo = 8'h01; end
      else if (m >= 4 && m <= 7) begin
        expRate = 8'hFC; expType = tv[4][f];
        expMode = (m == 5) ? 8'h12 : (m == 6) ? 8'h16 : (m == 7) ? 8'h11 : 8'h10;
      end else                     expRate = tv[0][f] | 8'h80;
    end
    chk({tag, " symRateCfg"}, symRateCfg, expSym);
    chk({tag, " freqCfg"}, freqCfg, expFreq);
    chk({tag, " codeRate"}, 32'(codeRate), 32'(expRate));
    chk({tag, " modType"}, 32'(modType), 32'(expType));
    chk({tag, " demodMode"}, 32'(demodMode), 32'(expMode));
    chk({tag, " turboFlag"}, 32'(turboFlag), 32'(expTurbo));
    @(negedge clk);
    chk({tag, " strobe ends (R10)"}, 32'({cfgValid, errMod, errFec, errLen}), 32'd0);
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 symRateCfg", symRateCfg, 32'd0);
    chk("R1 freqCfg", freqCfg, 32'd0);
    chk("R1 bytes", {codeRate, modType, demodMode, turboFlag}, 32'd0);
    chk("R1 strobes", 32'({cfgValid, errMod, errFec, errLen}), 32'd0);
  endtask

  task automatic loadTables;
    for (int f = 0; f < 5; f++) begin
      int depth = (f == 0) ? 8 : (f == 3) ? 2 : (f == 4) ? 10 : 6;
      for (int a = 0; a < depth; a++) writeTbl(f, a, 8'(f * 16 + a + 1));
    end
  endtask

  task automatic testMainModes;
    runTune("R3 R2 dvbs", 0, 3, 32'h01C9C380, 32'h00124F80, 10, 0, 0);
    runTune("R4 turbo qpsk", 1, 5, 32'h11223344, 32'h55667788, 10, 0, 0);
    runTune("R4 turbo 8psk", 2, 0, 32'hA1B2C3D4, 32'h0F1E2D3C, 10, 0, 0);
    runTune("R4 turbo 16qam", 3, 1, 32'h00000001, 32'h80000000, 10, 0, 0);
    runTune("R5 dcii combo", 4, 9, 32'h12345678, 32'h9ABCDEF0, 10, 0, 0);
    runTune("R5 dcii istream", 5, 2, 32'h00FF00FF, 32'hFF00FF00, 10, 0, 0);
    runTune("R5 dcii qstream", 6, 0, 32'hDEADBEEF, 32'hCAFEF00D, 10, 0, 0);
    runTune("R5 dcii oqpsk", 7, 4, 32'h0BADF00D, 32'h600DCAFE, 10, 0, 0);
    runTune("R6 dss", 8, 7, 32'h00BEBC20, 32'h001E8480, 10, 0, 0);
    runTune("R6 bpsk", 9, 0, 32'h00003E80, 32'h000E7EF0, 10, 0, 0);
  endtask

  task automatic testErrors;
    runTune("R7 dvbs fec 8", 0, 8, 32'h1, 32'h2, 10, 0, 2);
    runTune("R7 turbo16 fec 2", 3, 2, 32'h3, 32'h4, 10, 0, 2);
    runTune("R7 turbo qpsk fec 6", 1, 6, 32'h5, 32'h6, 10, 0, 2);
    runTune("R7 dcii fec 10", 6, 10, 32'h7, 32'h8, 10, 0, 2);
    runTune("R7 bpsk fec 9", 9, 9, 32'h9, 32'hA, 10, 0, 2);
    runTune("R8 mod 10", 10, 0, 32'hB, 32'hC, 10, 0, 1);
    runTune("R8 mod 255 bad fec", 255, 200, 32'hD, 32'hE, 10, 0, 1);
    runTune("R9 short frame", 0, 1, 32'h1234, 32'h5678, 9, 0, 3);
    runTune("R9 long frame", 0, 1, 32'h1234, 32'h5678, 11, 0, 3);
    runTune("R9 one byte", 0, 1, 32'h1234, 32'h5678, 1, 0, 3);
    runTune("R9 recover", 0, 1, 32'h00AA5501, 32'h77665544, 10, 0, 0);
  endtask

  task automatic testGapsAndTable;
    runTune("R12 gapped frame", 2, 4, 32'hCAFE0123, 32'h89ABCDEF, 10, 1, 0);
    writeTbl(0, 7, 8'h3C);
    runTune("R11 rewritten entry", 0, 7, 32'h1, 32'h2, 10, 0, 0);
    writeTbl(4, 9, 8'h5D);
    runTune("R11 rewritten dcii", 7, 9, 32'h3, 32'h4, 10, 0, 0);
    runTune("R10 back to back", 1, 1, 32'h44, 32'h55, 10, 0, 0);
  endtask

  initial begin
    testReset();
    loadTables();
    testMainModes();
    testErrors();
    testGapsAndTable();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule